// File: doc/BRIEF.md
# LCD Display Control Sequencer

This block sits between the display-buffer read path and the row and column driver stage of a small matrix LCD controller. It holds three control flags: display enable, force-all-on and inverse. A command port writes the three flags together. Each row of raw pixel bits read from the buffer passes through the block as a stream, and the flags decide the column drive value for each bit. The block also gates the column output-enable and the row drive levels. It runs a sleep/wake handshake with an external power block through a sleep request output and a power-good input.

Display enable takes priority over the other two flags. When it is clear, the block idles every driver and requests sleep. When it becomes set, the block first withdraws the sleep request. It waits in a wake state until power-good arrives, and only then lets the drivers go active. If power-good does not arrive within a programmable number of cycles, the block stops in a failure state with the drivers idle and reports a wake error. Clearing display enable is the only way out of that state. The flags act only on the output path and never write back to the buffer.

Top module: `lcd_dispctl_seq`

## Requirements
- R1: `cmd_ready` is always 1. On a clock edge with `cmd_valid` high, the flags load from `cmd_flags`, where bit 2 is display enable, bit 1 is force-all-on and bit 0 is inverse. The new values act from the cycle after that edge.
- R2: Outside the active state, `col_oe` and `row_oe` are 0, `col_drive` is all zeros, every 2-bit field of `row_lvl_out` is the ground code 2'b00, and `pix_out_valid` is 0.
- R3: `sleep_req` is 1 in the sleep state and in the failure state. It is 0 in the wake state and in the active state.
- R4: One edge after display enable reads 1 in the sleep state, the block enters the wake state. From the wake state it becomes active on the first edge at which `pwr_good` is 1, and from the next cycle `col_oe` and `row_oe` are 1.
- R5: While active with force-all-on set, every bit of `col_drive` is 1, whatever `pix_in_data` holds.
- R6: While active with inverse set and force-all-on clear, `col_drive` is the bitwise complement of `pix_in_data`. With both flags clear, it equals `pix_in_data`.
- R7: When force-all-on and inverse are both set, force-all-on wins and `col_drive` is all ones.
- R8: From any state, an edge at which display enable reads 0 moves the block to the sleep state.
- R9: The wake-state counter starts at 0 on entry and counts one per cycle. At an edge where `pwr_good` is 0 and the count equals `wake_limit`, the block enters the failure state. In that state `wake_err` is 1, the drivers stay idle, and the block stays there until display enable reads 0.
- R10: After reset, all flags are 0, the block is in the sleep state, `sleep_req` is 1, `wake_err` is 0 and all drivers are idle.
- R11: While active, `pix_out_valid` follows `pix_in_valid` and `pix_in_ready` follows `pix_out_ready`. Outside the active state, `pix_in_ready` is 1 and incoming pixels are discarded.
- R12: While active, `row_lvl_out` equals `row_lvl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Flag write strobe |
| cmd_ready | output | 1 | Always 1 |
| cmd_flags | input | 3 | {enable, force-all-on, inverse} |
| wake_limit | input | TW (8) | Wake timeout in cycles |
| pwr_good | input | 1 | Power restored |
| sleep_req | output | 1 | Request for the power block to sleep |
| wake_err | output | 1 | Wake timed out |
| pix_in_valid | input | 1 | Pixel row valid |
| pix_in_ready | output | 1 | Pixel row accepted |
| pix_in_data | input | COLS (16) | Raw pixel bits |
| pix_out_valid | output | 1 | Column drive valid |
| pix_out_ready | input | 1 | Downstream ready |
| col_drive | output | COLS (16) | Column drive values |
| col_oe | output | 1 | Column output-enable |
| row_lvl_in | input | ROWS*2 (16) | Row levels from the scanner |
| row_lvl_out | output | ROWS*2 (16) | Gated row levels |
| row_oe | output | 1 | Row drivers active |

## Verification
The timeout path is the hardest case to reach from the ports. It needs display enable set while power-good is held low for exactly `wake_limit`+1 cycles. The bench sets a short limit and holds `pwr_good` low to reach the failure state. It then clears enable, wakes again with a late power-good, and clears enable while still in the wake state, so that every exit from every state is covered. A behavioural model tracks each state and compares all outputs on every cycle, while flag combinations and back-pressure patterns are varied.

// File: rtl/lcd_dispctl_pkg.sv
package lcd_dispctl_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_WAKE   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_FAIL   = 2'd3
  } seq_state_e;

  localparam int ROW_CODE_W = 2;
  localparam logic [ROW_CODE_W-1:0] ROW_GND_CODE = 2'b00;

  localparam int FLAG_EN_BIT  = 2;
  localparam int FLAG_ALL_BIT = 1;
  localparam int FLAG_INV_BIT = 0;
endpackage

// File: rtl/lcd_flag_reg.sv
module lcd_flag_reg
  import lcd_dispctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_flags,
  output logic       flag_en,
  output logic       flag_all,
  output logic       flag_inv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_en  <= 1'b0;
      flag_all <= 1'b0;
      flag_inv <= 1'b0;
    end else if (wr_en) begin
      flag_en  <= wr_flags[FLAG_EN_BIT];
      flag_all <= wr_flags[FLAG_ALL_BIT];
      flag_inv <= wr_flags[FLAG_INV_BIT];
    end
  end
endmodule

// File: rtl/lcd_power_fsm.sv
module lcd_power_fsm
  import lcd_dispctl_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          pwr_good,
  input  logic [TW-1:0] limit,
  output logic          active,
  output logic          sleep_req,
  output logic          wake_err
);
  seq_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    if (!enable) begin
      state_d = ST_SLEEP;
    end else begin
      unique case (state_q)
        ST_SLEEP:  state_d = ST_WAKE;
        ST_WAKE: begin
          if (pwr_good)           state_d = ST_ACTIVE;
          else if (cnt_q == limit) state_d = ST_FAIL;
          else                     cnt_d   = cnt_q + 1'b1;
        end
        ST_ACTIVE: state_d = ST_ACTIVE;
        ST_FAIL:   state_d = ST_FAIL;
        default:   state_d = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active    = (state_q == ST_ACTIVE);
  assign sleep_req = (state_q == ST_SLEEP) || (state_q == ST_FAIL);
  assign wake_err  = (state_q == ST_FAIL);
endmodule

// File: rtl/lcd_col_path.sv
module lcd_col_path #(
  parameter int COLS = 16
) (
  input  logic            active,
  input  logic            flag_all,
  input  logic            flag_inv,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [COLS-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [COLS-1:0] out_data
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic shaped;
    always_comb begin
      if (flag_all)      shaped = 1'b1;
      else if (flag_inv) shaped = ~in_data[c];
      else               shaped = in_data[c];
    end
    assign out_data[c] = active & shaped;
  end

  assign out_valid = active & in_valid;
  assign in_ready  = active ? out_ready : 1'b1;
endmodule

// File: rtl/lcd_row_gate.sv
module lcd_row_gate
  import lcd_dispctl_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic                       active,
  input  logic [ROWS*ROW_CODE_W-1:0] lvl_in,
  output logic [ROWS*ROW_CODE_W-1:0] lvl_out
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign lvl_out[r*ROW_CODE_W +: ROW_CODE_W] =
      active ? lvl_in[r*ROW_CODE_W +: ROW_CODE_W] : ROW_GND_CODE;
  end
endmodule

// File: rtl/lcd_dispctl_seq.sv
module lcd_dispctl_seq #(
  parameter int COLS = 16,
  parameter int ROWS = 8,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_flags,
  input  logic [TW-1:0]   wake_limit,
  input  logic            pwr_good,
  output logic            sleep_req,
  output logic            wake_err,
  input  logic            pix_in_valid,
  output logic            pix_in_ready,
  input  logic [COLS-1:0] pix_in_data,
  output logic            pix_out_valid,
  input  logic            pix_out_ready,
  output logic [COLS-1:0] col_drive,
  output logic            col_oe,
  input  logic [ROWS*2-1:0] row_lvl_in,
  output logic [ROWS*2-1:0] row_lvl_out,
  output logic            row_oe
);
  logic flag_en, flag_all, flag_inv, active;

  assign cmd_ready = 1'b1;

  lcd_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_valid), .wr_flags(cmd_flags),
    .flag_en(flag_en), .flag_all(flag_all), .flag_inv(flag_inv)
  );

  lcd_power_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(flag_en), .pwr_good(pwr_good),
    .limit(wake_limit), .active(active), .sleep_req(sleep_req),
    .wake_err(wake_err)
  );

  lcd_col_path #(.COLS(COLS)) u_cols (
    .active(active), .flag_all(flag_all), .flag_inv(flag_inv),
    .in_valid(pix_in_valid), .in_ready(pix_in_ready), .in_data(pix_in_data),
    .out_valid(pix_out_valid), .out_ready(pix_out_ready), .out_data(col_drive)
  );

  lcd_row_gate #(.ROWS(ROWS)) u_rows (
    .active(active), .lvl_in(row_lvl_in), .lvl_out(row_lvl_out)
  );

  assign col_oe = active;
  assign row_oe = active;
endmodule

// File: rtl/lcd_dispctl_seq_chk.sv
module lcd_dispctl_seq_chk #(
  parameter int COLS = 16,
  parameter int ROWS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flag_en,
  input logic            flag_all,
  input logic            flag_inv,
  input logic            pwr_good,
  input logic            sleep_req,
  input logic            wake_err,
  input logic            col_oe,
  input logic [COLS-1:0] col_drive,
  input logic [COLS-1:0] pix_in_data,
  input logic [ROWS*2-1:0] row_lvl_out
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !col_oe |-> (col_drive == '0 && row_lvl_out == '0)); // R2
  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !col_oe); // R3
  AST_ACTIVE_AFTER_PG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_oe) |-> ($past(pwr_good) && !$past(sleep_req))); // R4
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (col_oe && flag_all) |-> (col_drive == '1)); // R5
  AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (col_oe && flag_inv && !flag_all) |-> (col_drive == ~pix_in_data)); // R6
  AST_EN_OFF_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> (sleep_req && !col_oe && !wake_err)); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> (sleep_req && !col_oe)); // R9
endmodule

bind lcd_dispctl_seq lcd_dispctl_seq_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .flag_all(flag_all),
  .flag_inv(flag_inv), .pwr_good(pwr_good), .sleep_req(sleep_req),
  .wake_err(wake_err), .col_oe(col_oe), .col_drive(col_drive),
  .pix_in_data(pix_in_data), .row_lvl_out(row_lvl_out)
);

// File: tb/lcd_dispctl_seq_tb.sv
module lcd_dispctl_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 16;
  localparam int ROWS = 8;
  localparam int TW   = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_flags = 0;
  logic [TW-1:0] wake_limit = 4;
  logic pwr_good = 0, sleep_req, wake_err;
  logic pix_in_valid = 0, pix_in_ready, pix_out_valid, pix_out_ready = 1;
  logic [COLS-1:0] pix_in_data = 0, col_drive;
  logic col_oe, row_oe;
  logic [ROWS*2-1:0] row_lvl_in = 0, row_lvl_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model: 0 sleep, 1 wake, 2 active, 3 fail
  int m_st = 0, m_cnt = 0;
  bit m_en = 0, m_all = 0, m_inv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_dispctl_seq #(.COLS(COLS), .ROWS(ROWS), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_flags(cmd_flags), .wake_limit(wake_limit), .pwr_good(pwr_good),
    .sleep_req(sleep_req), .wake_err(wake_err), .pix_in_valid(pix_in_valid),
    .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
    .col_drive(col_drive), .col_oe(col_oe), .row_lvl_in(row_lvl_in),
    .row_lvl_out(row_lvl_out), .row_oe(row_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_en = 0; m_all = 0; m_inv = 0;
    end else begin
      int nst, ncnt;
      nst = m_st; ncnt = 0;
      if (!m_en) nst = 0;
      else if (m_st == 0) nst = 1;
      else if (m_st == 1) begin
        if (pwr_good) nst = 2;
        else if (m_cnt == int'(wake_limit)) nst = 3;
        else ncnt = m_cnt + 1;
      end
      m_st = nst; m_cnt = ncnt;
      if (cmd_valid) begin
        m_en = cmd_flags[2]; m_all = cmd_flags[1]; m_inv = cmd_flags[0];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit act;
      logic [COLS-1:0] e_col;
      string creq;
      act = (m_st == 2);
      if (!act)      begin e_col = '0; creq = "R2 col_drive"; end
      else if (m_all) begin e_col = '1; creq = m_inv ? "R7 col_drive" : "R5 col_drive"; end
      else if (m_inv) begin e_col = ~pix_in_data; creq = "R6 col_drive inverse"; end
      else           begin e_col = pix_in_data; creq = "R6 col_drive direct"; end
      chk(col_drive === e_col, creq, 64'(col_drive), 64'(e_col));
      chk(sleep_req === (m_st == 0 || m_st == 3), "R3 sleep_req", 64'(sleep_req), 64'(m_st == 0 || m_st == 3));
      chk(wake_err === (m_st == 3), "R9 wake_err", 64'(wake_err), 64'(m_st == 3));
      chk(col_oe === act && row_oe === act, "R4 col_oe/row_oe", 64'({col_oe, row_oe}), 64'({act, act}));
      chk(row_lvl_out === (act ? row_lvl_in : '0), "R12 row_lvl_out", 64'(row_lvl_out), 64'(act ? row_lvl_in : '0));
      chk(pix_out_valid === (act & pix_in_valid), "R11 pix_out_valid", 64'(pix_out_valid), 64'(act & pix_in_valid));
      chk(pix_in_ready === (act ? pix_out_ready : 1'b1), "R11 pix_in_ready", 64'(pix_in_ready), 64'(act ? pix_out_ready : 1'b1));
      chk(cmd_ready === 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      pix_in_data  = 16'($urandom);
      pix_in_valid = 1'($urandom);
      pix_out_ready = 1'($urandom);
      row_lvl_in   = 16'($urandom);
    end
  endtask

  task automatic write_flags(input logic [2:0] f);
    @(negedge clk); #1;
    cmd_valid = 1; cmd_flags = f;
    @(negedge clk); #1;
    cmd_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    // R10: reset state
    chk(sleep_req === 1 && col_oe === 0 && wake_err === 0 && row_lvl_out === '0,
        "R10 reset state", 64'({sleep_req, col_oe, wake_err}), 64'b100);
    rst_n = 1;
    step(3);
    // R9: timeout with power-good held low
    wake_limit = 4; pwr_good = 0;
    write_flags(3'b100);
    step(10);
    chk(wake_err === 1, "R9 timeout reached", 64'(wake_err), 64'd1);
    // R8: clear enable from fail
    write_flags(3'b000);
    step(2);
    chk(wake_err === 0 && sleep_req === 1, "R8 fail to sleep", 64'({wake_err, sleep_req}), 64'b01);
    // R4: wake with late power-good
    wake_limit = 20;
    write_flags(3'b100);
    step(4);
    pwr_good = 1;
    step(2);
    chk(col_oe === 1, "R4 active after power-good", 64'(col_oe), 64'd1);
    step(20);
    write_flags(3'b110); step(20);  // R5
    write_flags(3'b101); step(20);  // R6
    write_flags(3'b111); step(20);  // R7
    write_flags(3'b100); step(20);
    // R8: clear from active
    write_flags(3'b011);
    step(1);
    chk(col_oe === 0 && sleep_req === 1, "R8 active to sleep", 64'({col_oe, sleep_req}), 64'b01);
    step(10); // R2: flags other than enable ignored while asleep
    // R8: clear during wake
    pwr_good = 0;
    write_flags(3'b100);
    step(2);
    write_flags(3'b000);
    step(4);
    // R1: reactivate with a direct write and fast power-good
    pwr_good = 1;
    write_flags(3'b101);
    step(3);
    chk(col_oe === 1, "R1 flags applied", 64'(col_oe), 64'd1);
    step(30);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule